// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a clocked host to an external asynchronous static RAM organised as 128K words of 16 bits. The host hands over one access at a time through a valid/ready handshake that carries a word address, write data, a read/write flag and a two-bit byte mask. The controller then drives the memory's active-low chip select, write strobe, output-enable strobe and the two byte-lane strobes, together with per-lane data drive enables for the bidirectional data bus. The pad cells stay outside the block.

The memory's limits are given in nanoseconds, along with the clock period. From these the controller derives a number of cycles for the read access phase and for the write pulse. Each count is the ceiling of the limit over the period and is never below one. Writes are controlled by the write strobe. Address and selects are set up for one cycle before the strobe falls. Data stays driven for one cycle after the strobe rises and is released after that. A quiet turnaround cycle separates any change of direction on the bus. A read returns its data with a single-cycle valid pulse, and any byte not requested in the mask comes back as zero.

Top module: `async_sram_ctrl`

## Requirements
- R1: While idle, reqReady is 1, rspValid is 0, memCeN, memWeN, memOeN, memUbN and memLbN are all 1, and memDqOe is 2'b00.
- R2: A write, counted from the edge that accepts it, is one setup cycle (memCeN=0, memWeN=1), then WP_CYC cycles with memWeN=0, then one hold cycle with memWeN=1 and the data still driven, then idle with drivers off. memOeN stays 1 for the whole write.
- R3: Mask bit 0 selects the lower lane (data bits 7:0, strobe memLbN, drive enable memDqOe[0]). Mask bit 1 selects the upper lane (bits 15:8, memUbN, memDqOe[1]). A lane whose mask bit is 0 keeps its strobe at 1 and is never driven.
- R4: A read holds memCeN=0, memOeN=0 and memWeN=1 for RD_CYC cycles with memDqOe=2'b00. The read data is sampled at the clock edge that ends the last of those cycles.
- R5: Each read produces a one-cycle rspValid pulse in the first cycle after the read phase. rspData holds the sampled word with every unmasked byte forced to zero. A write produces no rspValid.
- R6: RD_CYC = max(1, ceil(max(T_RC_NS, T_AA_NS, T_OE_NS) / CLK_NS)) and WP_CYC = max(1, ceil(max(T_WP_NS, T_DW_NS) / CLK_NS)).
- R7: An access whose direction differs from the previous access since reset is preceded by exactly one cycle in which all strobes are 1 and nothing is driven. The first access after reset, and an access in the same direction as the previous one, get no such cycle.
- R8: A request is taken when reqValid and reqReady are both 1 at a clock edge. reqReady then stays 0 until the access ends. That is RD_CYC edges for a read and WP_CYC+2 edges for a write, plus one edge when a turnaround cycle is inserted.
- R9: memOeN is never 0 while any bit of memDqOe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| rspValid | output | 1 | One-cycle read data valid |
| rspData | output | 16 | Read data, unmasked bytes zero |
| memAddr | output | 17 | Memory address |
| memCeN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memUbN | output | 1 | Upper lane strobe, active low |
| memLbN | output | 1 | Lower lane strobe, active low |
| memDqOut | output | 16 | Data to drive onto the bus |
| memDqOe | output | 2 | Per-lane data drive enable |
| memDqIn | input | 16 | Data sampled from the bus |

## Verification
The bench builds the block with a 10 ns clock, a 25 ns read access limit and a 12 ns write pulse limit. This gives a three-cycle read phase and a two-cycle write pulse, so the counters run over several values instead of collapsing to one cycle. With these values, a read phase cut short or a write pulse cut short shows up directly in the measured strobe widths and handshake latencies. The stimulus mixes write-after-write, read-after-read and both direction changes with full, single-lane and empty masks. A behavioural memory model in the bench returns a filler byte on lanes that are not selected, which exposes any failure to zero the unrequested bytes.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_WSET, ST_WPULSE, ST_WHOLD, ST_READ
  } ctrlState_t;

  // strobes from control to datapath, active high intent
  typedef struct packed {
    logic loadReq;
    logic selChip;
    logic writeLow;
    logic outEn;
    logic driveData;
    logic sampleRd;
  } strobe_t;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cyclesFor(int ns, int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int RD_CYC = 1,
  parameter int WP_CYC = 1,
  parameter int CNT_W  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  ctrlState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic opWrite, haveLast, lastWrite;
  logic accept;

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);

  assign accept = (state == ST_IDLE) && reqValid;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    case (state)
      ST_IDLE: if (reqValid) begin
        if (haveLast && (lastWrite != reqWrite)) stateNext = ST_TURN;
        else if (reqWrite) stateNext = ST_WSET;
        else begin
          stateNext = ST_READ;
          cntNext   = RD_LOAD;
        end
      end
      ST_TURN: begin
        if (opWrite) stateNext = ST_WSET;
        else begin
          stateNext = ST_READ;
          cntNext   = RD_LOAD;
        end
      end
      ST_WSET: begin
        stateNext = ST_WPULSE;
        cntNext   = WP_LOAD;
      end
      ST_WPULSE: begin
        if (cnt == '0) stateNext = ST_WHOLD;
        else cntNext = cnt - 1'b1;
      end
      ST_WHOLD: stateNext = ST_IDLE;
      ST_READ: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else cntNext = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      opWrite   <= 1'b0;
      haveLast  <= 1'b0;
      lastWrite <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (accept) begin
        opWrite   <= reqWrite;
        haveLast  <= 1'b1;
        lastWrite <= reqWrite;
      end
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strb.loadReq   = accept;
    strb.selChip   = (state == ST_WSET) || (state == ST_WPULSE) ||
                     (state == ST_WHOLD) || (state == ST_READ);
    strb.writeLow  = (state == ST_WPULSE);
    strb.outEn     = (state == ST_READ);
    strb.driveData = (state == ST_WSET) || (state == ST_WPULSE) || (state == ST_WHOLD);
    strb.sampleRd  = (state == ST_READ) && (cnt == '0);
  end

endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  laneEnN,
  output logic [DATA_W-1:0] memDqOut,
  output logic [LANES-1:0]  memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] rdMasked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (strb.loadReq) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      maskQ <= reqMask;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = dataQ;
  assign memCeN   = ~strb.selChip;
  assign memWeN   = ~strb.writeLow;
  assign memOeN   = ~strb.outEn;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign laneEnN[i] = ~(strb.selChip & maskQ[i]);
    assign memDqOe[i] = strb.driveData & maskQ[i];
    assign rdMasked[8*i +: 8] = maskQ[i] ? memDqIn[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.sampleRd;
      if (strb.sampleRd) rspData <= rdMasked;
    end
  end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 10,
  parameter int T_AA_NS = 10,
  parameter int T_OE_NS = 4,
  parameter int T_WP_NS = 7,
  parameter int T_DW_NS = 5,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic [LANES-1:0]  memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RD_CYC = cyclesFor(maxOf(maxOf(T_RC_NS, T_AA_NS), T_OE_NS), CLK_NS);
  localparam int WP_CYC = cyclesFor(maxOf(T_WP_NS, T_DW_NS), CLK_NS);
  localparam int CNT_W  = $clog2(maxOf(RD_CYC, WP_CYC)) + 1;

  strobe_t strb;
  logic [LANES-1:0] laneEnN;

  sramc_ctrl #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  sramc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .laneEnN(laneEnN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  assign memLbN = laneEnN[0];
  assign memUbN = laneEnN[LANES-1];

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memUbN,
  input logic              memLbN,
  input logic [DATA_W-1:0] memDqOut,
  input logic [LANES-1:0]  memDqOe
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && memOeN && memUbN && memLbN && memDqOe == '0)); // R1

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCeN)); // R2

  AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> ($stable(memDqOe) && $stable(memDqOut))); // R2

  AST_LOW_LANE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe[0] |-> !memLbN); // R3

  AST_HIGH_LANE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe[LANES-1] |-> !memUbN); // R3

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R5

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R8

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memDqOe == '0)); // R9

endmodule

bind async_sram_ctrl sramc_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
  .memUbN(memUbN), .memLbN(memLbN), .memDqOut(memDqOut), .memDqOe(memDqOe)
);

// File: tb/sim_async_sram_ctrl.sv
module sim_async_sram_ctrl;

  // bench build: 25 ns read -> 3 cycles, 12 ns pulse -> 2 cycles (R6)
  localparam int EXP_RD = 3;
  localparam int EXP_WP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic reqReady, rspValid;
  logic [15:0] rspData;
  logic [16:0] memAddr;
  logic memCeN, memWeN, memOeN, memUbN, memLbN;
  logic [15:0] memDqOut;
  logic [1:0]  memDqOe;
  logic [15:0] memDqIn;

  int checks = 0;
  int failures = 0;
  int contention = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  async_sram_ctrl #(
    .CLK_NS(10), .T_RC_NS(20), .T_AA_NS(25), .T_OE_NS(4),
    .T_WP_NS(12), .T_DW_NS(5)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memUbN(memUbN), .memLbN(memLbN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // behavioural memory
  logic [15:0] store [int unsigned];

  function automatic logic [15:0] peek(logic [16:0] a);
    if (store.exists(int'(a))) return store[int'(a)];
    return 16'h0000;
  endfunction

  always @(posedge memWeN) begin
    if (!memCeN) begin
      logic [15:0] w;
      w = peek(memAddr);
      if (!memLbN) w[7:0]  = memDqOe[0] ? memDqOut[7:0]  : 8'h5A;
      if (!memUbN) w[15:8] = memDqOe[1] ? memDqOut[15:8] : 8'h5A;
      store[int'(memAddr)] = w;
    end
  end

  always @(memCeN or memOeN or memWeN or memUbN or memLbN or memAddr) begin
    logic [15:0] v;
    v = peek(memAddr);
    memDqIn[7:0]  = (!memCeN && !memOeN && memWeN && !memLbN) ? v[7:0]  : 8'hEE;
    memDqIn[15:8] = (!memCeN && !memOeN && memWeN && !memUbN) ? v[15:8] : 8'hEE;
  end

  always @(negedge clk) begin
    cycles++;
    if (!memOeN && memDqOe != 2'b00) contention++;
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20000 * 10);
    failures++;
    $display("FAIL watchdog expired: actual=timeout expected=done");
    finishRun();
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkIdle(string req);
    check(req, {reqReady, rspValid, memCeN, memWeN, memOeN, memUbN, memLbN, memDqOe},
          {1'b1, 1'b0, 5'b11111, 2'b00});
  endtask

  typedef struct packed {
    logic        isWr;
    logic [16:0] addr;
    logic [15:0] data;
    logic [1:0]  mask;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    {1'b1, 17'h00010, 16'h1234, 2'b11, 16'h0000},
    {1'b1, 17'h1FFFF, 16'hBEEF, 2'b11, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 17'h00010, 16'hAB99, 2'b10, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'hAB34},
    {1'b1, 17'h00010, 16'h77CD, 2'b01, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b01, 16'h00CD},
    {1'b0, 17'h1FFFF, 16'h0000, 2'b10, 16'hBE00},
    {1'b0, 17'h1FFFF, 16'h0000, 2'b00, 16'h0000}
  };

  // one access, with per-cycle observation of the memory side
  task automatic doOp(input logic isWr, input logic [16:0] a, input logic [15:0] d,
                      input logic [1:0] m, input logic expTurn, input logic [15:0] expData);
    int lat = 1, weLow = 0, oeLow = 0, quiet = 0, drive = 0, early = 0;
    logic [1:0] laneSeen = 2'b00, oeSeen = 2'b00;
    logic oeInWrite = 1'b0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = isWr; reqAddr = a; reqWdata = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0;
    while (!reqReady) begin
      if (!memWeN) weLow++;
      if (!memOeN) oeLow++;
      if (isWr && !memOeN) oeInWrite = 1'b1;
      if (memCeN && memWeN && memOeN && memUbN && memLbN && memDqOe == 2'b00) quiet++;
      if (memDqOe != 2'b00) drive++;
      if (!memLbN) laneSeen[0] = 1'b1;
      if (!memUbN) laneSeen[1] = 1'b1;
      oeSeen |= memDqOe;
      if (rspValid) early++;
      @(negedge clk);
      lat++;
    end
    lat--;
    if (isWr) begin
      check("R8 write latency", lat, EXP_WP + 2 + int'(expTurn));
      check("R2 write pulse cycles", weLow, EXP_WP);
      check("R2 oe held high in write", int'(oeInWrite), 0);
      check("R2 drive cycles", drive, (m != 2'b00) ? EXP_WP + 2 : 0);
      check("R3 write lane strobes", int'(laneSeen), int'(m));
      check("R3 write lane drive", int'(oeSeen), int'(m));
      check("R5 no rsp on write", int'(rspValid), 0);
    end else begin
      check("R8 read latency", lat, EXP_RD + int'(expTurn));
      check("R4 oe low cycles", oeLow, EXP_RD);
      check("R4 no drive in read", int'(oeSeen), 0);
      check("R3 read lane strobes", int'(laneSeen), int'(m));
      check("R5 rsp pulse present", int'(rspValid), 1);
      check("R5 read data", int'(rspData), int'(expData));
    end
    check("R5 no early rsp", early, 0);
    check("R7 turnaround cycles", quiet, int'(expTurn));
    @(negedge clk);
    check("R5 rsp single cycle", int'(rspValid), 0);
    checkIdle("R1 idle after access");
  endtask

  initial begin
    logic prevValid;
    logic prevWr;
    prevValid = 1'b0;
    prevWr = 1'b0;
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    // request held off while busy is not taken twice (R8)
    for (int i = 0; i < NV; i++) begin
      logic turn;
      turn = prevValid && (prevWr != VECS[i].isWr);
      doOp(VECS[i].isWr, VECS[i].addr, VECS[i].data, VECS[i].mask, turn, VECS[i].exp);
      prevValid = 1'b1;
      prevWr = VECS[i].isWr;
    end

    // R7: reset forgets direction, write after a read gets no turnaround
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkIdle("R1 re-reset");
    rstN = 1'b1;
    doOp(1'b1, 17'h00020, 16'hC3A5, 2'b11, 1'b0, 16'h0000);
    doOp(1'b1, 17'h00021, 16'h0F0F, 2'b00, 1'b0, 16'h0000);
    doOp(1'b0, 17'h00020, 16'h0000, 2'b11, 1'b1, 16'hC3A5);
    // R3: empty-mask write left the word untouched
    doOp(1'b0, 17'h00021, 16'h0000, 2'b11, 1'b0, 16'h0000);

    check("R9 no bus contention", contention, 0);
    finishRun();
  end

endmodule